// File: doc/BRIEF.md
# Strap Capture and Clock Mode Selector

This block sits at the front of a clock generator. It samples the board's configuration straps during the power-good window and turns the captured settings into an operating mode. The straps are two binary frequency selects, a third select that an external comparator has already resolved into low, middle or high, and a current-multiplier strap. The held straps form a 5-bit frequency code. A software-written code can replace that code, and a software-written pair of loop divider values can replace the default divider values that each code implies.

The result goes to the synthesis and output stages as plain control levels. These are the selected code, flags for buffered, high-impedance and test operation, the loop divider values, and a one-cycle strobe whenever the code changes so that downstream dividers can reload. In test mode a small synchronous counter, clocked by the external test clock, provides divide-by-2, divide-by-4 and divide-by-8 outputs for the different output groups. No valid/ready handshake is used because every input and output is a static control level.

Top module: `fsel_top`

## Requirements
- R1: While `pwrgd_n` is sampled low on a rising `clk` edge, the three selects and the multiplier strap are captured on that edge. While it is high they hold. A captured strap shows on `freq_code` two edges after it was driven, and `mult_lat` shows the captured multiplier strap one edge after capture.
- R2: The strap code is {0, level, sel1, sel0}. The level field is 00 for low, 01 for middle and 10 for high. A comparator input of 11 is taken as high.
- R3: When code bits [3:2] are 00 (unbuffered), none of `buffered`, `tristate` or `test_mode` is set.
- R4: When code bits [3:2] are 10 or 11, `buffered` is set and the other two flags are clear.
- R5: When code bits [3:2] are 01, low bits 00 set only `tristate`, low bits 01 set only `test_mode`, and low bits 10 or 11 set no flag.
- R6: With `reg_code_sel` high, `freq_code` equals `reg_code` (all 5 bits) one edge later, and the strap code is not used. Bit 4 plays no part in the flags or the default dividers.
- R7: With `reg_div_sel` low, `div_n`/`div_m` follow the code. Level field not 01: low bits 00 give 140/30, 01 give 210/30, 10 give 838/60, 11 give 279/30. Level field 01: low bits 10 give 314/30, 11 give 349/30, 00 and 01 give 140/30.
- R8: With `reg_div_sel` high, `div_n`/`div_m` equal `reg_n`/`reg_m` one edge later, and later changes of the code leave them unchanged.
- R9: `code_upd` is high for exactly the cycle in which `freq_code` shows a new value. A write of an unchanged code raises no strobe.
- R10: `tclk_div` is zero outside test mode. After test mode begins, the first two `test_clk` rising edges only resynchronise, and after 2+k edges `tclk_div` equals k modulo 8 (bit 0 is divide-by-2, bit 2 is divide-by-8). Leaving test mode clears the counter after two `test_clk` edges.
- R11: During reset `freq_code` is 0, all flags and `code_upd` are 0, `mult_lat` is 0, `div_n`/`div_m` are 140/30, and `tclk_div` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n | input | 1 | Active-low power-good; low opens the strap capture |
| sel0_pin | input | 1 | Frequency select strap, bit 0 |
| sel1_pin | input | 1 | Frequency select strap, bit 1 |
| sel2_lvl | input | 2 | Resolved three-level strap: 00 low, 01 middle, 10/11 high |
| mult_pin | input | 1 | Current-multiplier strap |
| test_clk | input | 1 | External test clock |
| reg_code_sel | input | 1 | Use the register code instead of the strap code |
| reg_code | input | 5 | Register frequency code |
| reg_div_sel | input | 1 | Use the register divider values |
| reg_n | input | 10 | Register loop N value |
| reg_m | input | 7 | Register loop M value |
| freq_code | output | 5 | Selected frequency code |
| buffered | output | 1 | 66 MHz group follows the external input, PCI at half of it |
| tristate | output | 1 | All clock outputs high impedance |
| test_mode | output | 1 | Outputs driven from the divided test clock |
| code_upd | output | 1 | One-cycle strobe on a code change |
| div_n | output | 10 | Loop N value in use |
| div_m | output | 7 | Loop M value in use |
| mult_lat | output | 1 | Captured multiplier strap |
| tclk_div | output | 3 | Test clock divided by 2, 4 and 8 |

## Verification
The checker watches four things on every cycle: the three mode flags never overlap, the multiplier strap holds while the capture is closed, the strobe coincides exactly with a change of the code, and each register override reaches its output one edge later. The scenarios cover the rest. These are the mapping of every strap combination to a code, its flags and its default dividers, the two-edge latency from pin to code, and the hold of the straps after power-good rises. They also cover the counter in the test-clock domain, including its resynchronisation delay, its wrap and its restart on a second entry into test mode.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int CODE_W = 5;
  localparam int N_W    = 10;
  localparam int M_W    = 7;
  localparam int LVL_W  = 2;

  localparam logic [LVL_W-1:0] LVL_LO  = 2'b00;
  localparam logic [LVL_W-1:0] LVL_MID = 2'b01;
  localparam logic [LVL_W-1:0] LVL_HI  = 2'b10;

  typedef struct packed {
    logic buffered;
    logic tristate;
    logic test;
  } mode_t;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_t;

  // Mode flags from the level field and the two low select bits.
  function automatic mode_t decode_mode(input logic [3:0] c);
    mode_t r;
    r = '0;
    unique case (c[3:2])
      2'b00: r = '0;
      2'b01: begin
        r.tristate = (c[1:0] == 2'b00);
        r.test     = (c[1:0] == 2'b01);
      end
      default: r.buffered = 1'b1;
    endcase
    return r;
  endfunction

  // Default loop divider pair implied by a code.
  function automatic div_t default_div(input logic [3:0] c);
    div_t d;
    d.m = M_W'(30);
    if (c[3:2] == 2'b01) begin
      unique case (c[1:0])
        2'b10:   d.n = N_W'(314);
        2'b11:   d.n = N_W'(349);
        default: d.n = N_W'(140);
      endcase
    end else begin
      unique case (c[1:0])
        2'b00: d.n = N_W'(140);
        2'b01: d.n = N_W'(210);
        2'b10: begin
          d.n = N_W'(838);
          d.m = M_W'(60);
        end
        default: d.n = N_W'(279);
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic              sel0_pin,
  input  logic              sel1_pin,
  input  logic [LVL_W-1:0]  sel2_lvl,
  input  logic              mult_pin,
  output logic [CODE_W-1:0] strap_code,
  output logic              mult_lat
);

  logic [LVL_W-1:0] lvl_norm;

  // The comparator value 11 is folded into the high level.
  always_comb begin
    lvl_norm = (sel2_lvl == 2'b11) ? LVL_HI : sel2_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_code <= '0;
      mult_lat   <= 1'b0;
    end else if (!pwrgd_n) begin
      strap_code <= {1'b0, lvl_norm, sel1_pin, sel0_pin};
      mult_lat   <= mult_pin;
    end
  end

endmodule

// File: rtl/fsel_mode_sel.sv
module fsel_mode_sel
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              reg_code_sel,
  input  logic [CODE_W-1:0] reg_code,
  input  logic              reg_div_sel,
  input  logic [N_W-1:0]    reg_n,
  input  logic [M_W-1:0]    reg_m,
  output logic [CODE_W-1:0] code_q,
  output mode_t             mode_q,
  output logic [N_W-1:0]    n_q,
  output logic [M_W-1:0]    m_q,
  output logic              upd_q
);

  localparam div_t RST_DIV = default_div(4'b0000);

  logic [CODE_W-1:0] nxt_code;
  div_t              nxt_div;

  always_comb begin
    nxt_code = reg_code_sel ? reg_code : strap_code;
    if (reg_div_sel) begin
      nxt_div.n = reg_n;
      nxt_div.m = reg_m;
    end else begin
      nxt_div = default_div(nxt_code[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= '0;
      n_q    <= RST_DIV.n;
      m_q    <= RST_DIV.m;
      upd_q  <= 1'b0;
    end else begin
      code_q <= nxt_code;
      mode_q <= decode_mode(nxt_code[3:0]);
      n_q    <= nxt_div.n;
      m_q    <= nxt_div.m;
      upd_q  <= (nxt_code != code_q);
    end
  end

endmodule

// File: rtl/fsel_test_div.sv
module fsel_test_div #(
  parameter int DIV_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             test_clk,
  input  logic             rst_n,
  input  logic             test_en,
  output logic [DIV_W-1:0] tdiv
);

  logic [SYNC_N-1:0] en_sh;
  logic              en_s;
  logic [DIV_W-1:0]  cnt;

  // Bring the mode flag into the test clock domain.
  always_ff @(posedge test_clk or negedge rst_n) begin
    if (!rst_n) en_sh <= '0;
    else        en_sh <= {en_sh[SYNC_N-2:0], test_en};
  end

  assign en_s = en_sh[SYNC_N-1];

  // Every bit switches on the same edge; the counter restarts from zero on each entry.
  always_ff @(posedge test_clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en_s) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < DIV_W; g++) begin : g_tap
    assign tdiv[g] = cnt[g] & en_s;
  end

endmodule

// File: rtl/fsel_top.sv
module fsel_top
  import fsel_pkg::*;
#(
  parameter int TDIV_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic              sel0_pin,
  input  logic              sel1_pin,
  input  logic [LVL_W-1:0]  sel2_lvl,
  input  logic              mult_pin,
  input  logic              test_clk,
  input  logic              reg_code_sel,
  input  logic [CODE_W-1:0] reg_code,
  input  logic              reg_div_sel,
  input  logic [N_W-1:0]    reg_n,
  input  logic [M_W-1:0]    reg_m,
  output logic [CODE_W-1:0] freq_code,
  output logic              buffered,
  output logic              tristate,
  output logic              test_mode,
  output logic              code_upd,
  output logic [N_W-1:0]    div_n,
  output logic [M_W-1:0]    div_m,
  output logic              mult_lat,
  output logic [TDIV_W-1:0] tclk_div
);

  logic [CODE_W-1:0] strap_code;
  mode_t             mode;

  fsel_strap_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrgd_n    (pwrgd_n),
    .sel0_pin   (sel0_pin),
    .sel1_pin   (sel1_pin),
    .sel2_lvl   (sel2_lvl),
    .mult_pin   (mult_pin),
    .strap_code (strap_code),
    .mult_lat   (mult_lat)
  );

  fsel_mode_sel u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_code   (strap_code),
    .reg_code_sel (reg_code_sel),
    .reg_code     (reg_code),
    .reg_div_sel  (reg_div_sel),
    .reg_n        (reg_n),
    .reg_m        (reg_m),
    .code_q       (freq_code),
    .mode_q       (mode),
    .n_q          (div_n),
    .m_q          (div_m),
    .upd_q        (code_upd)
  );

  assign buffered  = mode.buffered;
  assign tristate  = mode.tristate;
  assign test_mode = mode.test;

  fsel_test_div #(.DIV_W(TDIV_W), .SYNC_N(SYNC_N)) u_tdiv (
    .test_clk (test_clk),
    .rst_n    (rst_n),
    .test_en  (mode.test),
    .tdiv     (tclk_div)
  );

endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
  import fsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwrgd_n,
  input logic              mult_lat,
  input logic [CODE_W-1:0] freq_code,
  input logic              buffered,
  input logic              tristate,
  input logic              test_mode,
  input logic              code_upd,
  input logic              reg_code_sel,
  input logic [CODE_W-1:0] reg_code,
  input logic              reg_div_sel,
  input logic [N_W-1:0]    reg_n,
  input logic [M_W-1:0]    reg_m,
  input logic [N_W-1:0]    div_n,
  input logic [M_W-1:0]    div_m
);

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrgd_n) |-> $stable(mult_lat));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buffered, tristate, test_mode}));

  // R6
  reg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_code_sel |=> (freq_code == $past(reg_code)));

  // R8
  reg_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_div_sel |=> ((div_n == $past(reg_n)) && (div_m == $past(reg_m))));

  // R9
  upd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_upd == (freq_code != $past(freq_code)));

  // R5
  test_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (freq_code[3:0] == 4'b0101));

endmodule

bind fsel_top fsel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwrgd_n      (pwrgd_n),
  .mult_lat     (mult_lat),
  .freq_code    (freq_code),
  .buffered     (buffered),
  .tristate     (tristate),
  .test_mode    (test_mode),
  .code_upd     (code_upd),
  .reg_code_sel (reg_code_sel),
  .reg_code     (reg_code),
  .reg_div_sel  (reg_div_sel),
  .reg_n        (reg_n),
  .reg_m        (reg_m),
  .div_n        (div_n),
  .div_m        (div_m)
);

// File: tb/fsel_top_tb.sv
module fsel_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrgd_n = 1'b0;
  logic       sel0_pin = 1'b0, sel1_pin = 1'b0, mult_pin = 1'b0;
  logic [1:0] sel2_lvl = 2'b00;
  logic       test_clk = 1'b0;
  logic       reg_code_sel = 1'b0, reg_div_sel = 1'b0;
  logic [4:0] reg_code = '0;
  logic [9:0] reg_n = '0;
  logic [6:0] reg_m = '0;
  logic [4:0] freq_code;
  logic       buffered, tristate, test_mode, code_upd, mult_lat;
  logic [9:0] div_n;
  logic [6:0] div_m;
  logic [2:0] tclk_div;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fsel_top u_dut (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .sel0_pin(sel0_pin),
    .sel1_pin(sel1_pin), .sel2_lvl(sel2_lvl), .mult_pin(mult_pin),
    .test_clk(test_clk), .reg_code_sel(reg_code_sel), .reg_code(reg_code),
    .reg_div_sel(reg_div_sel), .reg_n(reg_n), .reg_m(reg_m),
    .freq_code(freq_code), .buffered(buffered), .tristate(tristate),
    .test_mode(test_mode), .code_upd(code_upd), .div_n(div_n), .div_m(div_m),
    .mult_lat(mult_lat), .tclk_div(tclk_div)
  );

  // {lvl[1:0], sel1, sel0, mult, exp_code[4:0], buf, tri, test}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 1'b1, 5'b00000, 3'b000},
    {2'b00, 1'b0, 1'b1, 1'b0, 5'b00001, 3'b000},
    {2'b00, 1'b1, 1'b0, 1'b1, 5'b00010, 3'b000},
    {2'b00, 1'b1, 1'b1, 1'b0, 5'b00011, 3'b000},
    {2'b10, 1'b0, 1'b0, 1'b1, 5'b01000, 3'b100},
    {2'b10, 1'b1, 1'b1, 1'b0, 5'b01011, 3'b100},
    {2'b01, 1'b0, 1'b0, 1'b1, 5'b00100, 3'b010},
    {2'b01, 1'b0, 1'b1, 1'b0, 5'b00101, 3'b001},
    {2'b01, 1'b1, 1'b0, 1'b1, 5'b00110, 3'b000},
    {2'b01, 1'b1, 1'b1, 1'b0, 5'b00111, 3'b000},
    {2'b11, 1'b1, 1'b0, 1'b1, 5'b01010, 3'b100}
  };

  // Divider table of R7.
  function automatic logic [16:0] exp_div(input logic [3:0] c);
    if (c[3:2] == 2'b01) begin
      if (c[1:0] == 2'b10) return {10'd314, 7'd30};
      if (c[1:0] == 2'b11) return {10'd349, 7'd30};
      return {10'd140, 7'd30};
    end
    case (c[1:0])
      2'b00:   return {10'd140, 7'd30};
      2'b01:   return {10'd210, 7'd30};
      2'b10:   return {10'd838, 7'd60};
      default: return {10'd279, 7'd30};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tpulse(input int n);
    for (int i = 0; i < n; i++) begin
      #2 test_clk = 1'b1;
      #2 test_clk = 1'b0;
    end
    #1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] keep;
    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11 code", 32'(freq_code), 0);
    chk("R11 flags", 32'({buffered, tristate, test_mode, code_upd}), 0);
    chk("R11 div", 32'({div_n, div_m}), 32'({10'd140, 7'd30}));
    chk("R11 mult", 32'(mult_lat), 0);
    chk("R11 tdiv", 32'(tclk_div), 0);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {sel2_lvl, sel1_pin, sel0_pin, mult_pin} = VEC[v][12:8];
      pwrgd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 code", 32'(freq_code), 32'(VEC[v][7:3]));
      chk("R3/R4/R5 flags", 32'({buffered, tristate, test_mode}), 32'(VEC[v][2:0]));
      chk("R7 div", 32'({div_n, div_m}), 32'(exp_div(VEC[v][6:3])));
      chk("R1 mult", 32'(mult_lat), 32'(VEC[v][8]));
    end

    // R1: two-edge latency, then hold once power-good rises
    {sel2_lvl, sel1_pin, sel0_pin, mult_pin} = 5'b00_01_0;
    @(negedge clk);
    chk("R1 one edge", 32'(freq_code), 32'(5'b01010));
    @(negedge clk);
    chk("R1 two edges", 32'(freq_code), 32'(5'b00001));
    chk("R1 mult capture", 32'(mult_lat), 0);
    pwrgd_n = 1'b1;
    @(negedge clk);
    {sel2_lvl, sel1_pin, sel0_pin, mult_pin} = 5'b10_11_1;
    repeat (4) @(negedge clk);
    chk("R1 hold code", 32'(freq_code), 32'(5'b00001));
    chk("R1 hold mult", 32'(mult_lat), 0);
    chk("R9 quiet", 32'(code_upd), 0);

    // R6: register code overrides, bit 4 ignored by decoding
    reg_code_sel = 1'b1;
    reg_code = 5'b11001;
    @(negedge clk);
    chk("R6 code", 32'(freq_code), 32'(5'b11001));
    chk("R6 flags", 32'({buffered, tristate, test_mode}), 32'(3'b100));
    chk("R6 div", 32'({div_n, div_m}), 32'({10'd210, 7'd30}));
    chk("R9 strobe", 32'(code_upd), 1);
    @(negedge clk);
    chk("R9 one cycle", 32'(code_upd), 0);
    reg_code = 5'b01100;
    @(negedge clk);
    chk("R6 lvl11", 32'({buffered, tristate, test_mode}), 32'(3'b100));
    reg_code = 5'b10111;
    @(negedge clk);
    chk("R6 mid11", 32'({div_n, div_m}), 32'({10'd349, 7'd30}));
    chk("R6 mid11 flags", 32'({buffered, tristate, test_mode}), 0);
    @(negedge clk);
    reg_code = 5'b10111;
    @(negedge clk);
    chk("R9 same code", 32'(code_upd), 0);

    // R8: divider override holds across code changes
    reg_div_sel = 1'b1;
    reg_n = 10'h3A5;
    reg_m = 7'h55;
    @(negedge clk);
    chk("R8 div", 32'({div_n, div_m}), 32'({10'h3A5, 7'h55}));
    reg_code = 5'b00010;
    @(negedge clk);
    chk("R8 kept", 32'({div_n, div_m}), 32'({10'h3A5, 7'h55}));
    reg_div_sel = 1'b0;
    @(negedge clk);
    chk("R7 back", 32'({div_n, div_m}), 32'({10'd838, 7'd60}));

    // R10: test divider
    reg_code = 5'b00101;
    @(negedge clk);
    chk("R10 mode", 32'(test_mode), 1);
    chk("R10 idle", 32'(tclk_div), 0);
    tpulse(2);
    chk("R10 sync", 32'(tclk_div), 0);
    tpulse(5);
    chk("R10 count5", 32'(tclk_div), 5);
    tpulse(6);
    chk("R10 wrap", 32'(tclk_div), 3);
    @(negedge clk);
    reg_code = 5'b00000;
    @(negedge clk);
    tpulse(2);
    chk("R10 off", 32'(tclk_div), 0);
    keep = freq_code;
    chk("R10 left", 32'(keep), 0);
    reg_code = 5'b00101;
    @(negedge clk);
    tpulse(3);
    chk("R10 restart", 32'(tclk_div), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule